// File: doc/BRIEF.md
# Edge-Triggered Parallel Line Sampler

This block watches a bus of parallel digital input lines and takes a snapshot of them whenever a chosen edge appears. Each line has two enable bits, one for rising edges and one for falling edges. When one or more lines show an edge whose kind is enabled for that line, the block raises one event pulse. In the same clock it captures the present state of every line that a third mask, the sample mask, selects.

The inputs first pass through a resynchronizer. Edges are found by comparing each synchronized line with its value one clock earlier. The edge masks and the sample mask are independent, so a line can trigger captures without being captured, and the reverse. The event pulse is meant to be routed to an output terminal.

Captured data is held with a valid flag until the consumer acknowledges it. If a new event arrives before that acknowledge, the new capture replaces the old one and a sticky overflow flag is raised.

Top module: `chg_detect_sampler`

## Requirements
- R1: An input line going from 0 to 1 while its bit in `rise_en` is 1 makes `event_pulse` high for one clock. The pulse appears after the third rising clock edge that follows the input change: two synchronizer stages, then the event register.
- R2: An input line going from 1 to 0 while its bit in `fall_en` is 1 makes `event_pulse` high for one clock, with the same latency as R1.
- R3: A transition on a line whose enable bit for that direction is 0 produces no event pulse and leaves `cap_valid` unchanged.
- R4: Any number of qualifying edges detected in the same clock, on any lines and of either kind, produce exactly one event pulse, one clock wide.
- R5: In the clock in which `event_pulse` is high, `cap_data` bit i equals the post-edge synchronized value of line i when `sample_mask[i]` is 1, and 0 otherwise. This holds whatever `rise_en` and `fall_en` are.
- R6: `cap_valid` rises together with `event_pulse`. It stays high until a clock in which `cap_ack` is 1, and it goes low after that clock unless a new event occurs in it.
- R7: An event detected while `cap_valid` is 1 and `cap_ack` is 0 sets `overflow`, and the new capture overwrites `cap_data`. `overflow` then stays 1 until reset.
- R8: Synchronous active-low reset clears `event_pulse`, `cap_valid`, `overflow` and `cap_data`. Reset loads the synchronizer and the previous-value register with the current input, so a static input gives no event after reset, whatever its value.
- R9: An event detected in the same clock as `cap_ack` leaves `cap_valid` at 1 with the new data and does not set `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | LINES (32) | Asynchronous parallel input lines |
| rise_en | input | LINES | Per-line enable for rising-edge detection |
| fall_en | input | LINES | Per-line enable for falling-edge detection |
| sample_mask | input | LINES | Lines captured on an event; other bits read 0 |
| cap_ack | input | 1 | Consumer acknowledge of the held capture |
| event_pulse | output | 1 | One-clock pulse per detection clock |
| cap_data | output | LINES | Captured line values |
| cap_valid | output | 1 | Capture held and not yet acknowledged |
| overflow | output | 1 | Sticky: a capture was overwritten before acknowledge |

## Verification
The bound checker checks the handshake on every cycle:
- `cap_valid` is high whenever `event_pulse` is.
- `cap_valid` holds without an acknowledge and clears after one unless a new event arrives.
- `overflow` is set on an unacknowledged overwrite and never falls.
- Captured bits outside the sample mask are always zero.

Which edges qualify, the three-clock latency, the merging of simultaneous edges and the absence of false events after reset depend on the input history. Only the bench's scenarios show these. The bench sweeps every from/to pair of a four-line configuration under varied masks for this purpose.

// File: rtl/cds_pkg.sv
// Shared types for the change-detection sampler.
package cds_pkg;
    // Action applied to the capture holding register in one clock.
    typedef enum logic [1:0] {
        CAP_HOLD  = 2'd0,
        CAP_LOAD  = 2'd1,
        CAP_CLEAR = 2'd2
    } cap_action_t;
endpackage

// File: rtl/cds_sync.sv
// Multi-stage resynchronizer for a bus of asynchronous lines.
// Assumes each line is independently asynchronous. No bus coherence is
// claimed. Reset loads every stage with the raw input, so the chain
// starts out settled.
module cds_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first stage samples the asynchronous bus.
            always_ff @(posedge clk) begin
                stg[0] <= d_async;
            end
        end else begin : g_next
            // Purpose: later stages shift; reset preloads the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= d_async;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/cds_edge_qual.sv
// Per-line edge qualifier. Compares the synchronized lines with their
// values one clock earlier. It flags a hit when any line shows an edge
// whose kind is enabled for that line. Assumes init_val equals the value
// the synchronizer is loaded with during reset.
module cds_edge_qual #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] init_val,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    output logic             hit
);
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] line_hit;

    // Purpose: remember last clock's synchronized values.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= init_val;
        else        prev <= cur;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        // Purpose: qualify rising and falling edges of one line.
        always_comb begin
            line_hit[i] = (rise_en[i] &  cur[i] & ~prev[i]) |
                          (fall_en[i] & ~cur[i] &  prev[i]);
        end
    end

    // Purpose: merge all line hits into one detection flag.
    always_comb begin
        hit = |line_hit;
    end
endmodule

// File: rtl/cds_capture.sv
// Capture register with a valid/acknowledge handshake and a sticky
// overflow flag. Also registers the event pulse. Assumes hit is high
// for one clock per detection and is already synchronous.
module cds_capture
    import cds_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] sample_mask,
    input  logic             ack,
    output logic             event_pulse,
    output logic [WIDTH-1:0] data,
    output logic             valid,
    output logic             overflow
);
    cap_action_t act;

    // Purpose: decide the valid-flag action; a new event wins over ack.
    always_comb begin
        if (hit)                act = CAP_LOAD;
        else if (valid && ack)  act = CAP_CLEAR;
        else                    act = CAP_HOLD;
    end

    // Purpose: register the one-clock event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) event_pulse <= 1'b0;
        else        event_pulse <= hit;
    end

    // Purpose: load masked line values on an event.
    always_ff @(posedge clk) begin
        if (!rst_n)               data <= '0;
        else if (act == CAP_LOAD) data <= cur & sample_mask;
    end

    // Purpose: maintain the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            case (act)
                CAP_LOAD:  valid <= 1'b1;
                CAP_CLEAR: valid <= 1'b0;
                default:   valid <= valid;
            endcase
        end
    end

    // Purpose: sticky flag for a capture overwritten before acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     overflow <= 1'b0;
        else if (hit && valid && !ack)  overflow <= 1'b1;
    end
endmodule

// File: rtl/chg_detect_sampler.sv
// Change-detection sampler top level. It resynchronizes the input bus,
// detects enabled edges per line, and on any detection pulses
// event_pulse and captures the lines picked by sample_mask. Assumes the
// masks are synchronous to clk.
module chg_detect_sampler #(
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    input  logic [LINES-1:0] rise_en,
    input  logic [LINES-1:0] fall_en,
    input  logic [LINES-1:0] sample_mask,
    input  logic             cap_ack,
    output logic             event_pulse,
    output logic [LINES-1:0] cap_data,
    output logic             cap_valid,
    output logic             overflow
);
    logic [LINES-1:0] din_s;
    logic             hit;

    cds_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (din),
        .d_sync  (din_s)
    );

    cds_edge_qual #(.WIDTH(LINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (din_s),
        .init_val (din),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .hit      (hit)
    );

    cds_capture #(.WIDTH(LINES)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .cur         (din_s),
        .sample_mask (sample_mask),
        .ack         (cap_ack),
        .event_pulse (event_pulse),
        .data        (cap_data),
        .valid       (cap_valid),
        .overflow    (overflow)
    );
endmodule

// File: rtl/cds_checker.sv
// Port-level protocol checker for chg_detect_sampler, attached by bind.
module cds_checker #(
    parameter int LINES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] sample_mask,
    input logic             cap_ack,
    input logic             event_pulse,
    input logic [LINES-1:0] cap_data,
    input logic             cap_valid,
    input logic             overflow
);
    // R6: a pulse always comes with a held capture.
    a_r6_valid_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> cap_valid);

    // R6: without an acknowledge a held capture stays held.
    a_r6_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_ack) |=> cap_valid);

    // R6, R9: an acknowledge clears valid unless a new event lands.
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_ack) |=> (!cap_valid || event_pulse));

    // R7: an event over an unacknowledged capture raises overflow.
    a_r7_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_ack) |=> (!event_pulse || overflow));

    // R7: overflow is sticky.
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R5: no bit outside the sample mask is ever captured as 1.
    a_r5_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> ((cap_data & ~$past(sample_mask)) == '0));
endmodule

bind chg_detect_sampler cds_checker #(.LINES(LINES)) u_cds_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_mask (sample_mask),
    .cap_ack     (cap_ack),
    .event_pulse (event_pulse),
    .cap_data    (cap_data),
    .cap_valid   (cap_valid),
    .overflow    (overflow)
);

// File: tb/chg_detect_sampler_bench.sv
module chg_detect_sampler_bench;
    localparam int N = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n;
    logic [N-1:0] din, rise_en, fall_en, smask;
    logic         ack;
    logic         ev, cvalid, ovf;
    logic [N-1:0] cdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    chg_detect_sampler #(.LINES(N)) u_chg_detect_sampler (
        .clk(clk), .rst_n(rst_n), .din(din), .rise_en(rise_en),
        .fall_en(fall_en), .sample_mask(smask), .cap_ack(ack),
        .event_pulse(ev), .cap_data(cdata), .cap_valid(cvalid),
        .overflow(ovf)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Reset with a static input; expect no event and cleared outputs.
    task automatic do_reset(input logic [N-1:0] v);
        int n = 0;
        din = v; rst_n = 1'b0; ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ev && !cvalid && !ovf && cdata == '0, "R8 reset state",
            {ev, cvalid, ovf, 1'b0, 28'(cdata)}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (ev) n++;
        end
        chk(n == 0, "R8 no false event", n, 0);
    endtask

    // Drive a new value and wait three edges; optionally ack in the detect clock.
    task automatic edge3(input logic [N-1:0] v, input bit ack_at_detect);
        din = v;
        repeat (2) @(negedge clk);
        if (ack_at_detect) ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // One sweep scenario from value f to value t.
    task automatic run(input logic [N-1:0] f, input logic [N-1:0] t,
                       input logic [N-1:0] re, input logic [N-1:0] fe,
                       input logic [N-1:0] sm);
        int n = 0, at = -1;
        logic [N-1:0] d = '0;
        logic [N-1:0] rq, fq;
        string tag;
        rise_en = re; fall_en = fe; smask = sm; din = f; ack = 1'b1;
        repeat (6) @(negedge clk);
        ack = 1'b0;
        chk(!cvalid, "R6 ack drained", cvalid, 0);
        rq = ~f & t & re;
        fq = f & ~t & fe;
        if ($countones({rq, fq}) > 1) tag = "R4";
        else if (rq != '0)            tag = "R1";
        else if (fq != '0)            tag = "R2";
        else                          tag = "R3";
        din = t;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (ev) begin
                n++;
                if (at < 0) at = k;
                d = cdata;
            end
        end
        if ((rq | fq) != '0) begin
            chk(n == 1, {tag, " one pulse"}, n, 1);
            chk(at == 3, {tag, " latency"}, at, 3);
            chk(d == (t & sm), "R5 captured data", d, t & sm);
            chk(cvalid, "R6 valid held", cvalid, 1);
        end else begin
            chk(n == 0, "R3 no pulse", n, 0);
            chk(!cvalid, "R3 valid unchanged", cvalid, 0);
        end
    endtask

    initial begin
        rise_en = '0; fall_en = '0; smask = '0; ack = 1'b0;
        do_reset(4'hA);

        for (int f = 0; f < 16; f++) begin
            for (int t = 0; t < 16; t++) begin
                run(N'(f), N'(t), N'(f * 3 + t), N'(f + t * 5), N'((f * 7) ^ t));
            end
        end

        // Handshake sequence: R9 then R7.
        rise_en = '1; fall_en = '1; smask = '1; din = '0; ack = 1'b1;
        repeat (6) @(negedge clk);
        ack = 1'b0;
        edge3(4'h1, 1'b0);
        chk(ev && cvalid && cdata == 4'h1, "R6 first capture", cdata, 1);
        repeat (2) @(negedge clk);
        edge3(4'h3, 1'b1);
        chk(ev && cvalid, "R9 valid kept on ack+event", cvalid, 1);
        chk(cdata == 4'h3, "R9 new data", cdata, 3);
        chk(!ovf, "R9 no overflow", ovf, 0);
        @(negedge clk);
        chk(cvalid, "R9 valid still held", cvalid, 1);
        edge3(4'h7, 1'b0);
        chk(ovf, "R7 overflow set", ovf, 1);
        chk(cdata == 4'h7, "R7 overwrite", cdata, 7);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        chk(!cvalid, "R6 ack clears", cvalid, 0);
        chk(ovf, "R7 overflow sticky", ovf, 1);

        // Second reset with a different static input.
        do_reset(4'h5);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule